// File: doc/BRIEF.md
# Centre-aligned sawtooth PWM generator

This block produces one pulse-width-modulated output from a free-running up-counter. When the counter wraps it forms a sawtooth carrier. The block still centres the pulse on the middle of each carrier period. This is possible because the on-interval is taken as a window around the midpoint count rather than as a single compare threshold. A separate left value and right value set how far the pulse reaches on each side of the centre. Equal values give a symmetric pulse. A mid-carrier marker rises halfway through every period, which is the point farthest from the switch points, so it can start a current-sense conversion. The counter value is also an output, so further comparators elsewhere can share the same carrier.

A width select trades resolution for carrier frequency by using only the low bits of the counter: 14, 13, 12 or 11 bits. The select and the two switch-point values are copied into shadow registers only at a period boundary, so a period is never cut short or glitched. The synchronous reset is intended to be driven from a clock-locked indication. While it is low, the counter is held at zero and the shadows follow the inputs, so the first period after release uses the values presented during reset.

Top module: `centre_pwm`

## Requirements
- R1: While `lock_rst_ni` is low at a rising clock edge, `count_o`, `pwm_o` and `mid_o` are 0 after that edge.
- R2: Out of reset, `count_o` rises by one each clock and wraps from 2^N-1 to 0. N is the active carrier width, equal to 14 minus the shadowed `width_sel_i` (0 gives 14, 1 gives 13, 2 gives 12, 3 gives 11).
- R3: `width_sel_i`, `left_i` and `right_i` are captured during reset and in the clock where the count wraps to 0. Changing them at any other time leaves the current period unchanged: its length and its number of high `pwm_o` cycles.
- R4: With M = 2^(N-1), a switch value v is clamped to E(v) = M when v is all ones or when v > M, and is E(v) = v otherwise. `pwm_o` is high in the cycle after count c exactly when M - E(left) <= c < M + E(right).
- R5: Over one period, `pwm_o` is high for E(left)+E(right) cycles. When both values are 0 this is 0 cycles, and it covers the whole period when both clamp to M.
- R6: `mid_o` is high in the cycle after count c exactly when c >= M. It rises once per period, one clock after the count reaches M, and falls one clock after the count wraps to 0.
- R7: A new width takes effect only at the wrap. The next period then starts from 0 and lasts 2^N clocks of the new width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier clock |
| lock_rst_ni | input | 1 | Synchronous active-low reset, driven from clock lock |
| width_sel_i | input | 2 | Carrier width select, active width 14 minus value |
| left_i | input | 13 | Pulse extent before the carrier midpoint |
| right_i | input | 13 | Pulse extent after the carrier midpoint |
| pwm_o | output | 1 | Registered PWM output |
| mid_o | output | 1 | Registered mid-carrier marker |
| count_o | output | 14 | Carrier count for shared comparators |

## Verification
`count_o` is a register that updates at the clock edge. `pwm_o` and `mid_o` are each due one clock after the count value they decode, and a new set of shadow values shows up in the count sequence of the period that begins at the wrap. The bench keeps its own model, which it advances at each rising edge and which queues the output triple due after that edge. A monitor then compares that triple at the following falling edge. It also totals the high `pwm_o` cycles against the count value seen one sample earlier, and checks each completed period against the duty the model queued when that period started.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  parameter int unsigned MAX_W = 14;
  parameter int unsigned NUM_W = 4;
  localparam int unsigned SEL_W = $clog2(NUM_W);
  localparam int unsigned WID_W = $clog2(MAX_W + 1);
  localparam int unsigned SW_W  = MAX_W - 1;

  typedef logic [MAX_W-1:0] cnt_t;
  typedef logic [MAX_W:0]   ext_t;
  typedef logic [SW_W-1:0]  sw_t;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [WID_W-1:0] wid_t;

  // active carrier width for a select code
  function automatic wid_t width_of(sel_t s);
    return wid_t'(int'(MAX_W) - int'(s));
  endfunction

  // centre count of an N-bit carrier
  function automatic ext_t mid_of(wid_t w);
    return ext_t'(1) << (w - wid_t'(1));
  endfunction

  // last count before the wrap
  function automatic ext_t top_of(wid_t w);
    return (ext_t'(1) << w) - ext_t'(1);
  endfunction

  // switch extent clamped to half a period; all ones means full half
  function automatic ext_t eff_of(sw_t v, wid_t w);
    ext_t m;
    ext_t e;
    m = mid_of(w);
    e = ext_t'(v);
    if ((&v) || (e > m)) return m;
    return e;
  endfunction

  function automatic ext_t lo_of(sw_t left, wid_t w);
    return mid_of(w) - eff_of(left, w);
  endfunction

  function automatic ext_t hi_of(sw_t right, wid_t w);
    return mid_of(w) + eff_of(right, w);
  endfunction
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import cpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t sel_i,
  output cnt_t count_o,
  output logic wrap_o,
  output wid_t width_o
);
  cnt_t cnt_q;
  sel_t sel_q;
  wid_t width;
  logic at_top;

  assign width  = width_of(sel_q);
  assign at_top = (ext_t'(cnt_q) == top_of(width));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= sel_i;
    end else if (at_top) begin
      cnt_q <= '0;
      sel_q <= sel_i;
    end else begin
      cnt_q <= cnt_q + cnt_t'(1);
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = at_top;
  assign width_o = width;
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import cpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  sw_t  left_i,
  input  sw_t  right_i,
  output sw_t  left_o,
  output sw_t  right_o
);
  localparam int unsigned LANES = 2;
  sw_t lane_in [LANES];
  sw_t lane_q  [LANES];

  assign lane_in[0] = left_i;
  assign lane_in[1] = right_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (!rst_ni || load_i) lane_q[g] <= lane_in[g];
    end
  end

  assign left_o  = lane_q[0];
  assign right_o = lane_q[1];
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import cpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t count_i,
  input  wid_t width_i,
  input  sw_t  left_i,
  input  sw_t  right_i,
  output logic pwm_o,
  output logic mid_o
);
  ext_t cnt_x;
  ext_t lo_edge;
  ext_t hi_edge;
  logic in_window;
  logic past_mid;

  assign cnt_x     = ext_t'(count_i);
  assign lo_edge   = lo_of(left_i, width_i);
  assign hi_edge   = hi_of(right_i, width_i);
  assign in_window = (cnt_x >= lo_edge) && (cnt_x < hi_edge);
  assign past_mid  = (cnt_x >= mid_of(width_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pwm_o <= 1'b0;
      mid_o <= 1'b0;
    end else begin
      pwm_o <= in_window;
      mid_o <= past_mid;
    end
  end
endmodule

// File: rtl/centre_pwm.sv
module centre_pwm
  import cpwm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 lock_rst_ni,
  input  logic [SEL_W-1:0]     width_sel_i,
  input  logic [SW_W-1:0]      left_i,
  input  logic [SW_W-1:0]      right_i,
  output logic                 pwm_o,
  output logic                 mid_o,
  output logic [MAX_W-1:0]     count_o
);
  cnt_t carrier_count;
  logic carrier_wrap;
  wid_t carrier_width;
  sw_t  left_sh;
  sw_t  right_sh;

  pwm_carrier u_carrier (
    .clk_i   (clk_i),
    .rst_ni  (lock_rst_ni),
    .sel_i   (width_sel_i),
    .count_o (carrier_count),
    .wrap_o  (carrier_wrap),
    .width_o (carrier_width)
  );

  pwm_shadow u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (lock_rst_ni),
    .load_i  (carrier_wrap),
    .left_i  (left_i),
    .right_i (right_i),
    .left_o  (left_sh),
    .right_o (right_sh)
  );

  pwm_compare u_compare (
    .clk_i   (clk_i),
    .rst_ni  (lock_rst_ni),
    .count_i (carrier_count),
    .width_i (carrier_width),
    .left_i  (left_sh),
    .right_i (right_sh),
    .pwm_o   (pwm_o),
    .mid_o   (mid_o)
  );

  assign count_o = carrier_count;
endmodule

// File: rtl/centre_pwm_chk.sv
module centre_pwm_chk
  import cpwm_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input cnt_t count_i,
  input logic wrap_i,
  input wid_t width_i,
  input sw_t  left_i,
  input sw_t  right_i,
  input logic pwm_i,
  input logic mid_i
);
  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> count_i == $past(count_i) + cnt_t'(1));

  // R2
  count_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> count_i == '0);

  // R3
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(left_i) && $stable(right_i) && $stable(width_i));

  // R5
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_i == '0 && right_i == '0) |=> !pwm_i);

  // R6
  mid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mid_i) |-> ext_t'($past(count_i)) == mid_of($past(width_i)));

  // R6
  mid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mid_i) |-> $past(count_i) == '0);
endmodule

bind centre_pwm centre_pwm_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (lock_rst_ni),
  .count_i (carrier_count),
  .wrap_i  (carrier_wrap),
  .width_i (carrier_width),
  .left_i  (left_sh),
  .right_i (right_sh),
  .pwm_i   (pwm_o),
  .mid_i   (mid_o)
);

// File: tb/centre_pwm_tb.sv
module centre_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [12:0] left = '0;
  logic [12:0] right = '0;
  logic        pwm;
  logic        mid;
  logic [13:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit in_rst;
    int cnt;
    bit pwm;
    bit mid;
  } exp_t;

  exp_t sq[$];
  int   dq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  centre_pwm u_dut (
    .clk_i       (clk),
    .lock_rst_ni (rst_n),
    .width_sel_i (sel),
    .left_i      (left),
    .right_i     (right),
    .pwm_o       (pwm),
    .mid_o       (mid),
    .count_o     (count)
  );

  function automatic int clamp(int v, int m);
    if (v == 8191 || v > m) return m;
    return v;
  endfunction

  // model state, owned by the model process only
  int m_cnt = 0, m_l = 0, m_r = 0, m_sel = 0;

  always @(posedge clk) begin
    exp_t e;
    int n, m, top, lo, hi;
    if (!rst_n) begin
      m_cnt = 0; m_l = int'(left); m_r = int'(right); m_sel = int'(sel);
      e.in_rst = 1; e.cnt = 0; e.pwm = 0; e.mid = 0;
    end else begin
      n   = 14 - m_sel;
      m   = 1 << (n - 1);
      top = (1 << n) - 1;
      lo  = m - clamp(m_l, m);
      hi  = m + clamp(m_r, m);
      if (m_cnt == 0) dq.push_back(hi - lo);
      e.in_rst = 0;
      e.pwm = (m_cnt >= lo) && (m_cnt < hi);
      e.mid = (m_cnt >= m);
      if (m_cnt == top) begin
        m_cnt = 0; m_l = int'(left); m_r = int'(right); m_sel = int'(sel);
      end else begin
        m_cnt = m_cnt + 1;
      end
      e.cnt = m_cnt;
    end
    sq.push_back(e);
  end

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // monitor: per-cycle scoreboard plus per-period duty total
  int  prev_cnt = 0;
  int  highs = 0;
  bit  active = 0;
  always @(negedge clk) begin
    if (!done && sq.size() > 0) begin
      exp_t e;
      e = sq.pop_front();
      if (e.in_rst) begin
        check("R1 count", int'(count), 0);
        check("R1 pwm", int'(pwm), 0);
        check("R1 mid", int'(mid), 0);
        active = 0;
        highs = 0;
      end else begin
        check("R2 R7 count", int'(count), e.cnt);
        check("R4 pwm", int'(pwm), int'(e.pwm));
        check("R6 mid", int'(mid), int'(e.mid));
        if (prev_cnt == 0) begin
          highs = int'(pwm);
          active = 1;
        end else if (active) begin
          highs += int'(pwm);
        end
        if (active && count == 0 && prev_cnt != 0 && dq.size() > 0)
          check("R3/R5 duty", highs, dq.pop_front());
      end
      prev_cnt = int'(count);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    sel = 2'd3; left = 13'd100; right = 13'd100;
    cycles(5);
    rst_n = 1'b1;
    cycles(2048 * 2 + 700);
    // mid-period change must wait for the wrap (R3)
    left = 13'd300; right = 13'd50;
    cycles(2048 * 2);
    left = 13'd0; right = 13'd0;
    cycles(2048 * 2);
    left = 13'd8191; right = 13'd8191;
    cycles(2048 + 900);
    // width change mid-period (R7)
    sel = 2'd2; left = 13'd1000; right = 13'd2047;
    cycles(4096 * 2);
    sel = 2'd1; left = 13'd4096; right = 13'd4096;
    cycles(8192 * 2);
    sel = 2'd0; left = 13'd5000; right = 13'd3000;
    cycles(16384 * 2 + 10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule